// File: doc/BRIEF.md
# Timed Page-Load Write Buffer

This block gathers byte writes into a 64-byte page register and then hands the whole page to a storage array in one timed programming period. The first accepted write opens a load session. It must arrive while the unlock detector asserts its grant. That write fixes the page for the session, and each later byte in the session must carry the same page number. The session stays open as long as bytes keep arriving within an inactivity window. When the window expires with no new byte, the buffer goes busy and counts out the program time. At the end of the program period it presents the page number, the page data and a per-byte valid mask to the array.

Bytes may come in any order, and a byte may be overwritten while the session is open. Only bytes that were actually loaded are marked valid, so the array leaves every other byte of the page untouched. A write event counts only when the write strobe and chip enable are both high and output enable is low. Writes are refused while the block is busy, and also during a fixed wake-up delay after reset. The load window, the program time and the wake-up delay are all parameters counted in clock cycles.

Top module: `page_load_buffer`

## Requirements
- R1: After reset is released, `busy` stays high for exactly WAKE_CYCLES clock cycles. During reset and during this delay, `commit_mask` is 0, `page_err` is 0, `prog_done` is 0, and every write is ignored.
- R2: A write event is accepted only in a cycle where `wr_en` and `chip_en` are 1 and `out_en` is 0. A write with `chip_en` low or with `out_en` high changes nothing, in the idle state and in an open session alike.
- R3: When no session is open and `unlock_grant` is 1, an accepted write opens a session. It locks page `wr_addr[14:6]`, stores `wr_data` at byte offset `wr_addr[5:0]`, and sets bit `wr_addr[5:0]` of `commit_mask` on the next clock.
- R4: Each byte accepted in a session restarts an inactivity window. A further byte presented up to LOAD_WINDOW cycles after the cycle of the previous accepted byte is taken. If LOAD_WINDOW cycles pass with no accepted byte, the program period starts and later bytes are ignored.
- R5: Within a session, bytes may be loaded in any offset order. Writing the same offset again replaces the stored byte, so the last value written is the one committed.
- R6: During a session, a write whose page bits 14:6 differ from the locked page is dropped. It sets `page_err`, which then stays 1 until reset. A dropped byte does not restart the inactivity window.
- R7: The program period keeps `busy` high for exactly PROG_CYCLES cycles, and writes during it are ignored. In its last cycle, `prog_done` pulses for one cycle. In that same cycle, `commit_stb` is high with `commit_page` equal to the locked page, `commit_mask` holding exactly the loaded offsets, and `commit_data` byte k (bits 8k+7:8k) holding the last value loaded at offset k.
- R8: After `prog_done`, `commit_mask` reads 0 and the page lock is released, so the next session may lock a different page.
- R9: An accepted write while no session is open and `unlock_grant` is 0 loads nothing. It still runs a full program period (`busy` high for PROG_CYCLES cycles, then `prog_done`), with `commit_mask` at 0 and no `commit_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write event |
| chip_en | input | 1 | Chip enable; writes need it high |
| out_en | input | 1 | Output enable; writes need it low |
| unlock_grant | input | 1 | Unlock detector grant, sampled with the session-opening write |
| wr_addr | input | 15 | Write address: page in 14:6, byte offset in 5:0 |
| wr_data | input | 8 | Write data |
| busy | output | 1 | High during the wake-up delay and the program period |
| page_err | output | 1 | Sticky flag: a byte for another page was dropped |
| prog_done | output | 1 | One-cycle pulse in the last program cycle |
| commit_stb | output | 1 | Commit strobe to the array; high with `prog_done` when any byte is valid |
| commit_page | output | 9 | Page number to program |
| commit_data | output | 512 | Page data, byte k in bits 8k+7:8k |
| commit_mask | output | 64 | Per-byte valid mask for the page |

## Verification
The assertions assume that write inputs are synchronous to `clk`, and that `unlock_grant` matters only in the cycle of the write that opens a session. The bench meets both assumptions by driving every input on the falling edge and holding `wr_en` for exactly one cycle per write. The program-period properties rely on the counter limits being small enough for `busy` to fall within a run. The bench therefore overrides LOAD_WINDOW, PROG_CYCLES and WAKE_CYCLES with short values. It places byte gaps right at the window limit and one cycle past it.

// File: rtl/page_load_buffer.sv
module page_load_buffer #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int OFFS_W      = 6,
  parameter int LOAD_WINDOW = 18750,
  parameter int PROG_CYCLES = 1250000,
  parameter int WAKE_CYCLES = 1250000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                chip_en,
  input  logic                                out_en,
  input  logic                                unlock_grant,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic                                busy,
  output logic                                page_err,
  output logic                                prog_done,
  output logic                                commit_stb,
  output logic [ADDR_W-OFFS_W-1:0]            commit_page,
  output logic [(1<<OFFS_W)*DATA_W-1:0]       commit_data,
  output logic [(1<<OFFS_W)-1:0]              commit_mask
);
  localparam int BYTES  = 1 << OFFS_W;
  localparam int PAGE_W = ADDR_W - OFFS_W;
  localparam int MAX_A  = (WAKE_CYCLES > PROG_CYCLES) ? WAKE_CYCLES : PROG_CYCLES;
  localparam int MAX_C  = (MAX_A > LOAD_WINDOW) ? MAX_A : LOAD_WINDOW;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] WAKE_END = CNT_W'(WAKE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOAD_END = CNT_W'(LOAD_WINDOW - 1);
  localparam logic [CNT_W-1:0] PROG_END = CNT_W'(PROG_CYCLES - 1);

  typedef enum logic [1:0] {S_WAKE, S_IDLE, S_LOAD, S_PROG} state_t;

  state_t                   state;
  logic [CNT_W-1:0]         cnt;
  logic [PAGE_W-1:0]        page_q;
  logic [BYTES-1:0]         mask_q;
  logic [BYTES*DATA_W-1:0]  buf_q;
  logic                     err_q;

  logic              wr_ok, take_first, take_next, stray, take;
  logic [PAGE_W-1:0] in_page;
  logic [OFFS_W-1:0] in_offs;

  assign wr_ok      = wr_en && chip_en && !out_en;
  assign in_page    = wr_addr[ADDR_W-1:OFFS_W];
  assign in_offs    = wr_addr[OFFS_W-1:0];
  assign take_first = (state == S_IDLE) && wr_ok && unlock_grant;
  assign take_next  = (state == S_LOAD) && wr_ok && (in_page == page_q);
  assign stray      = (state == S_LOAD) && wr_ok && (in_page != page_q);
  assign take       = take_first || take_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_WAKE;
      cnt    <= '0;
      page_q <= '0;
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (stray) err_q <= 1'b1;
      case (state)
        S_WAKE: begin
          if (cnt == WAKE_END) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_IDLE: begin
          if (wr_ok) begin
            cnt <= '0;
            if (unlock_grant) begin
              state  <= S_LOAD;
              page_q <= in_page;
            end else state <= S_PROG;
          end
        end
        S_LOAD: begin
          if (take_next) cnt <= '0;
          else if (cnt == LOAD_END) begin
            state <= S_PROG;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == PROG_END) begin
            state  <= S_IDLE;
            cnt    <= '0;
            mask_q <= '0;
            page_q <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
      if (take) mask_q[in_offs] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < BYTES; i++)
      if (take && in_offs == OFFS_W'(i))
        buf_q[i*DATA_W +: DATA_W] <= wr_data;
  end

  assign busy        = (state == S_WAKE) || (state == S_PROG);
  assign prog_done   = (state == S_PROG) && (cnt == PROG_END);
  assign commit_stb  = prog_done && (|mask_q);
  assign commit_page = page_q;
  assign commit_data = buf_q;
  assign commit_mask = mask_q;
  assign page_err    = err_q;
endmodule

// File: rtl/page_load_buffer_chk.sv
module page_load_buffer_chk #(
  parameter int BYTES = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             page_err,
  input logic             prog_done,
  input logic             commit_stb,
  input logic [BYTES-1:0] commit_mask
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !prog_done);

  p_done_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> busy);

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !busy);

  p_commit_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_stb |-> prog_done);

  p_mask_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(commit_mask));

  p_mask_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (commit_mask == '0));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
endmodule

bind page_load_buffer page_load_buffer_chk #(.BYTES(1 << OFFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .page_err   (page_err),
  .prog_done  (prog_done),
  .commit_stb (commit_stb),
  .commit_mask(commit_mask)
);

// File: tb/page_load_buffer_tb.sv
`timescale 1ns/1ps
module page_load_buffer_tb;
  localparam int WIN  = 8;
  localparam int PROG = 30;
  localparam int WAKE = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, chip_en = 1'b0, out_en = 1'b0, unlock_grant = 1'b0;
  logic [14:0]  wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic         busy, page_err, prog_done, commit_stb;
  logic [8:0]   commit_page;
  logic [511:0] commit_data;
  logic [63:0]  commit_mask;

  always #4 clk = ~clk;

  page_load_buffer #(
    .LOAD_WINDOW(WIN), .PROG_CYCLES(PROG), .WAKE_CYCLES(WAKE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .chip_en(chip_en), .out_en(out_en),
    .unlock_grant(unlock_grant), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .page_err(page_err), .prog_done(prog_done), .commit_stb(commit_stb),
    .commit_page(commit_page), .commit_data(commit_data), .commit_mask(commit_mask)
  );

  int n_tests = 0, n_fail = 0;
  int done_cnt = 0, commit_cnt = 0;
  logic [8:0]   cap_page;
  logic [511:0] cap_data;
  logic [63:0]  cap_mask;
  bit finished = 0;

  always @(negedge clk) begin
    if (rst_n && prog_done) begin
      done_cnt++;
      if (commit_stb) begin
        commit_cnt++;
        cap_page = commit_page;
        cap_data = commit_data;
        cap_mask = commit_mask;
      end
    end
  end

  typedef struct packed {
    logic [14:0] addr;
    logic [7:0]  data;
    logic [3:0]  gap;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{15'h2945, 8'h11, 4'd0},
    '{15'h297F, 8'h22, 4'd3},
    '{15'h2940, 8'h33, 4'd7},
    '{15'h2945, 8'h44, 4'd0},
    '{15'h2961, 8'h55, 4'd5},
    '{15'h2990, 8'h66, 4'd0},
    '{15'h2950, 8'h77, 4'd0},
    '{15'h297F, 8'h88, 4'd2}
  };

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d,
                          input logic g, input logic ce, input logic oe);
    wr_en = 1'b1; chip_en = ce; out_en = oe; unlock_grant = g;
    wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; chip_en = 1'b0; out_en = 1'b0; unlock_grant = 1'b0;
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (busy === lvl && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    int n, d0, c0;
    logic [63:0] exp_mask;
    logic [7:0]  exp_data [64];
    logic [8:0]  exp_page;
    logic        exp_err;
    bit          first;

    // R1: reset state
    idle(3);
    check_eq("R1 reset busy", 64'(busy), 64'd1);
    check_eq("R1 reset mask", commit_mask, 64'd0);
    check_eq("R1 reset err", 64'(page_err), 64'd0);
    check_eq("R1 reset done", 64'(prog_done), 64'd0);
    rst_n = 1'b1;
    n = 0;
    while (busy === 1'b1 && n < 1000) begin
      if (n == 2) begin
        wr_en = 1'b1; chip_en = 1'b1; unlock_grant = 1'b1; wr_addr = 15'h0101; wr_data = 8'hEE;
      end
      if (n == 3) begin
        wr_en = 1'b0; chip_en = 1'b0; unlock_grant = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    check_eq("R1 wake length", 64'(n), 64'(WAKE));
    check_eq("R1 write during wake ignored", commit_mask, 64'd0);

    // R2: inhibited writes in idle
    do_write(15'h0042, 8'hA1, 1'b1, 1'b0, 1'b0);
    check_eq("R2 chip_en low mask", commit_mask, 64'd0);
    check_eq("R2 chip_en low busy", 64'(busy), 64'd0);
    do_write(15'h0042, 8'hA2, 1'b1, 1'b1, 1'b1);
    check_eq("R2 out_en high mask", commit_mask, 64'd0);
    idle(WIN + 2);
    check_eq("R2 no session opened", 64'(busy), 64'd0);

    // R3 R5 R6: table-driven session
    exp_mask = '0; exp_err = 1'b0; exp_page = '0; first = 1;
    for (int i = 0; i < 64; i++) exp_data[i] = '0;
    for (int k = 0; k < 8; k++) begin
      idle(int'(VEC[k].gap));
      do_write(VEC[k].addr, VEC[k].data, 1'b1, 1'b1, 1'b0);
      if (first) begin
        exp_page = VEC[k].addr[14:6];
        first = 0;
      end
      if (VEC[k].addr[14:6] == exp_page) begin
        exp_mask[VEC[k].addr[5:0]] = 1'b1;
        exp_data[VEC[k].addr[5:0]] = VEC[k].data;
      end else exp_err = 1'b1;
      check_eq("R3 R5 mask after write", commit_mask, exp_mask);
      check_eq("R6 page_err after write", 64'(page_err), 64'(exp_err));
    end
    d0 = done_cnt; c0 = commit_cnt;
    count_level(1'b0, n);
    check_eq("R4 window expiry", 64'(n), 64'(WIN));
    count_level(1'b1, n);
    check_eq("R7 program length", 64'(n), 64'(PROG));
    check_eq("R7 one done pulse", 64'(done_cnt - d0), 64'd1);
    check_eq("R7 one commit", 64'(commit_cnt - c0), 64'd1);
    check_eq("R7 commit page", 64'(cap_page), 64'(exp_page));
    check_eq("R7 commit mask", cap_mask, exp_mask);
    for (int i = 0; i < 64; i++)
      if (exp_mask[i]) check_eq("R5 R7 commit byte", 64'(cap_data[i*8 +: 8]), 64'(exp_data[i]));
    check_eq("R8 mask cleared", commit_mask, 64'd0);
    check_eq("R6 err sticky", 64'(page_err), 64'd1);

    // R4 R2 R7 R8: window boundary on a new page
    do_write(15'h70C1, 8'hB1, 1'b1, 1'b1, 1'b0);
    idle(WIN - 1);
    do_write(15'h70C2, 8'hB2, 1'b0, 1'b1, 1'b0);
    check_eq("R4 byte at window edge taken", commit_mask, 64'h6);
    do_write(15'h70C7, 8'hB7, 1'b0, 1'b1, 1'b1);
    check_eq("R2 out_en high in session", commit_mask, 64'h6);
    idle(WIN - 1);
    check_eq("R4 window closed busy", 64'(busy), 64'd1);
    do_write(15'h70C3, 8'hB3, 1'b0, 1'b1, 1'b0);
    check_eq("R4 R7 late byte ignored", commit_mask, 64'h6);
    d0 = done_cnt;
    count_level(1'b1, n);
    check_eq("R7 done pulse second", 64'(done_cnt - d0), 64'd1);
    check_eq("R8 new page locked", 64'(cap_page), 64'h1C3);
    check_eq("R7 second commit mask", cap_mask, 64'h6);
    check_eq("R7 byte 1", 64'(cap_data[15:8]), 64'hB1);
    check_eq("R7 byte 2", 64'(cap_data[23:16]), 64'hB2);

    // R9: ungranted write runs an empty program period
    d0 = done_cnt; c0 = commit_cnt;
    do_write(15'h1234, 8'h5A, 1'b0, 1'b1, 1'b0);
    check_eq("R9 busy after ungranted", 64'(busy), 64'd1);
    check_eq("R9 mask empty", commit_mask, 64'd0);
    count_level(1'b1, n);
    check_eq("R9 program length", 64'(n), 64'(PROG));
    check_eq("R9 done pulse", 64'(done_cnt - d0), 64'd1);
    check_eq("R9 no commit", 64'(commit_cnt - c0), 64'd0);

    summary();
  end
endmodule